// File: doc/BRIEF.md
# SHA-256 Sigma and Sum Execution Unit

This unit runs the four scalar SHA-256 helper operations of a RISC-V core's scalar cryptography hash extension. Each cycle it takes an instruction word, the rs1 operand and an enable for the extension. It checks whether the word is one of the four operations and computes the result from the low 32 bits of rs1. The functions are the two message-schedule mixers (small sigma 0 and 1) and the two compression-round mixers (big sum 0 and 1). Each one XORs three terms. Two of the terms are always right rotates. The third is a rotate for the sum functions and a logical right shift for the sigma functions.

The 32-bit result is sign-extended to the register width XLEN, which is 32 or 64. It is registered once, together with the destination register index and two flags. One flag marks a valid result and the other marks an illegal instruction. Writeback to the register file and pipeline control are handled outside the unit.

Top module: `sha_mix_unit`

## Requirements
- R1: An instruction is recognised only when bits [6:0] are 0010011, bits [14:12] are 001 and bits [31:25] are 0001000. Any other value in these fields gives an illegal response.
- R2: Bits [24:20] select the function: 00000 is sum0, 00001 is sum1, 00010 is sig0, 00011 is sig1. Every other selector value gives an illegal response.
- R3: sig0 returns rotr(x,7) ^ rotr(x,18) ^ (x >> 3), where >> is a logical shift.
- R4: sig1 returns rotr(x,17) ^ rotr(x,19) ^ (x >> 10), where >> is a logical shift.
- R5: sum0 returns rotr(x,2) ^ rotr(x,13) ^ rotr(x,22).
- R6: sum1 returns rotr(x,6) ^ rotr(x,11) ^ rotr(x,25).
- R7: x is rs1[31:0], and rs1 bits above 31 have no effect. The result is sign-extended from bit 31 to XLEN.
- R8: A recognised encoding with ext_en_i low gives an illegal response.
- R9: An accepted valid input raises result_valid_o, and only result_valid_o, on the next clock edge. An illegal response raises illegal_o, and only illegal_o, on the next edge. Each flag lasts one cycle per input.
- R10: rd_o carries bits [11:7] of the accepted instruction. Register 0 is treated like any other destination.
- R11: After reset, result_o, rd_o, result_valid_o and illegal_o are all zero.
- R12: Without an accepted input, result_o and rd_o keep their values and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operand are present |
| ext_en_i | input | 1 | Hash extension enabled |
| insn_i | input | 32 | Instruction word |
| rs1_i | input | XLEN | Source operand |
| result_o | output | XLEN | Sign-extended result |
| rd_o | output | 5 | Destination register index |
| result_valid_o | output | 1 | Result is valid this cycle |
| illegal_o | output | 1 | Illegal instruction response |

## Verification
Every result, flag and destination index is due exactly one clock edge after the cycle in which the input is presented. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, so each check sees the registered response to exactly one input. After the last input, valid_i is dropped and the outputs are sampled on the following edges to confirm that the flags clear and the result holds. The 32-bit and 64-bit instances get the same stimulus, and each is compared with the expected value at its own width.

// File: rtl/sha_mix_pkg.sv
package sha_mix_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_FUNCS = 4;
  localparam int unsigned SEL_W   = 5;

  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [2:0] F3_SHA     = 3'b001;
  localparam logic [6:0] F7_SHA     = 7'b0001000;

  // encoding of selector[1:0] when selector[4:2] == 0
  typedef enum logic [1:0] {
    FN_SUM0 = 2'd0,
    FN_SUM1 = 2'd1,
    FN_SIG0 = 2'd2,
    FN_SIG1 = 2'd3
  } sha_fn_e;

  // rotate/shift amounts per function, term index 0..2
  function automatic int unsigned fn_amt(int unsigned fn, int unsigned term);
    case (fn)
      0: return (term == 0) ? 2  : (term == 1) ? 13 : 22;
      1: return (term == 0) ? 6  : (term == 1) ? 11 : 25;
      2: return (term == 0) ? 7  : (term == 1) ? 18 : 3;
      default: return (term == 0) ? 17 : (term == 1) ? 19 : 10;
    endcase
  endfunction

  // third term is a logical shift for the schedule mixers
  function automatic bit fn_third_is_shift(int unsigned fn);
    return fn >= 2;
  endfunction

  function automatic logic [WORD_W-1:0] rotr(logic [WORD_W-1:0] v, int unsigned n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction
endpackage

// File: rtl/sha_mix_decode.sv
module sha_mix_decode
  import sha_mix_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        match_o,
  output sha_fn_e     fn_o,
  output logic [4:0]  rd_o
);
  logic [SEL_W-1:0] sel;
  logic             fixed_ok;

  assign sel      = insn_i[24:20];
  assign fixed_ok = (insn_i[6:0] == OPC_IMM) && (insn_i[14:12] == F3_SHA) &&
                    (insn_i[31:25] == F7_SHA);
  assign match_o  = fixed_ok && (sel[SEL_W-1:2] == '0);
  assign fn_o     = sha_fn_e'(sel[1:0]);
  assign rd_o     = insn_i[11:7];
endmodule

// File: rtl/sha_mix_datapath.sv
module sha_mix_datapath
  import sha_mix_pkg::*;
(
  input  logic [WORD_W-1:0] x_i,
  input  sha_fn_e           fn_i,
  output logic [WORD_W-1:0] y_o
);
  logic [WORD_W-1:0] fn_res [N_FUNCS];

  for (genvar g = 0; g < N_FUNCS; g++) begin : g_fn
    localparam int unsigned A0 = fn_amt(g, 0);
    localparam int unsigned A1 = fn_amt(g, 1);
    localparam int unsigned A2 = fn_amt(g, 2);
    logic [WORD_W-1:0] t2;
    if (fn_third_is_shift(g)) begin : g_shr
      assign t2 = x_i >> A2;
    end else begin : g_ror
      assign t2 = rotr(x_i, A2);
    end
    assign fn_res[g] = rotr(x_i, A0) ^ rotr(x_i, A1) ^ t2;
  end

  assign y_o = fn_res[fn_i];
endmodule

// File: rtl/sha_mix_unit.sv
module sha_mix_unit
  import sha_mix_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            ext_en_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_i,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      rd_o,
  output logic            result_valid_o,
  output logic            illegal_o
);
  localparam int unsigned EXT_W = XLEN - WORD_W;

  logic              match;
  sha_fn_e           fn;
  logic [4:0]        rd_dec;
  logic [WORD_W-1:0] y32;
  logic [XLEN-1:0]   y_wide;
  logic              accept;
  logic              reject;

  sha_mix_decode u_dec (
    .insn_i (insn_i),
    .match_o(match),
    .fn_o   (fn),
    .rd_o   (rd_dec)
  );

  sha_mix_datapath u_dp (
    .x_i (rs1_i[WORD_W-1:0]),
    .fn_i(fn),
    .y_o (y32)
  );

  if (EXT_W > 0) begin : g_sext
    assign y_wide = {{EXT_W{y32[WORD_W-1]}}, y32};
  end else begin : g_flat
    assign y_wide = y32;
  end

  assign accept = valid_i && match && ext_en_i;
  assign reject = valid_i && !(match && ext_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o       <= '0;
      rd_o           <= '0;
      result_valid_o <= 1'b0;
      illegal_o      <= 1'b0;
    end else begin
      result_valid_o <= accept;
      illegal_o      <= reject;
      if (accept) begin
        result_o <= y_wide;
        rd_o     <= rd_dec;
      end
    end
  end
endmodule

// File: rtl/sha_mix_unit_chk.sv
module sha_mix_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            ext_en_i,
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] result_o,
  input logic [4:0]      rd_o,
  input logic            result_valid_o,
  input logic            illegal_o
);
  logic enc_ok;
  assign enc_ok = (insn_i[6:0] == 7'b0010011) && (insn_i[14:12] == 3'b001) &&
                  (insn_i[31:25] == 7'b0001000) && (insn_i[24:22] == 3'b000);

  // R9
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ext_en_i && enc_ok |=> result_valid_o && !illegal_o);

  // R8
  disabled_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ext_en_i |=> illegal_o && !result_valid_o);

  // R1
  nonmatch_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !enc_ok |=> illegal_o && !result_valid_o);

  // R12
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !result_valid_o && !illegal_o);

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(rd_o));

  // R10
  rd_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ext_en_i && enc_ok |=> rd_o == $past(insn_i[11:7]));

  // R9
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({result_valid_o, illegal_o}));

  // R7
  if (XLEN > 32) begin : g_sx
    sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      result_valid_o |-> (result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}}));
  end
endmodule

bind sha_mix_unit sha_mix_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ext_en_i(ext_en_i),
  .insn_i(insn_i), .rs1_i(rs1_i), .result_o(result_o), .rd_o(rd_o),
  .result_valid_o(result_valid_o), .illegal_o(illegal_o)
);

// File: tb/sim_sha_mix_unit.sv
`timescale 1ns/1ps
module sim_sha_mix_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        en = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] rs1 = '0;

  logic [63:0] res64;
  logic [4:0]  rd64;
  logic        v64, ill64;
  logic [31:0] res32;
  logic [4:0]  rd32;
  logic        v32, ill32;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sha_mix_unit #(.XLEN(64)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ext_en_i(en), .insn_i(insn),
    .rs1_i(rs1), .result_o(res64), .rd_o(rd64), .result_valid_o(v64), .illegal_o(ill64)
  );
  sha_mix_unit #(.XLEN(32)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ext_en_i(en), .insn_i(insn),
    .rs1_i(rs1[31:0]), .result_o(res32), .rd_o(rd32), .result_valid_o(v32), .illegal_o(ill32)
  );

  function automatic logic [31:0] rr(logic [31:0] v, int n);
    logic [63:0] d;
    d = {v, v} >> n;
    return d[31:0];
  endfunction

  // sel: 0 sum0, 1 sum1, 2 sig0, 3 sig1
  function automatic logic [31:0] model(int sel, logic [31:0] x);
    case (sel)
      0: return rr(x, 2) ^ rr(x, 13) ^ rr(x, 22);
      1: return rr(x, 6) ^ rr(x, 11) ^ rr(x, 25);
      2: return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
      default: return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] sel, logic [4:0] rd,
                                     logic [2:0] f3, logic [6:0] opc);
    return {f7, sel, 5'd0, f3, rd, opc};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // drive one input, check the registered response on the next edge
  task automatic run(string req, logic [31:0] i, logic [63:0] op, logic e,
                     bit expect_ok, int sel);
    logic [31:0] y;
    @(negedge clk);
    valid = 1'b1; en = e; insn = i; rs1 = op;
    @(posedge clk);
    #1;
    chk(req, {62'd0, v64, ill64}, {62'd0, expect_ok, !expect_ok});
    chk(req, {62'd0, v32, ill32}, {62'd0, expect_ok, !expect_ok});
    if (expect_ok) begin
      y = model(sel, op[31:0]);
      chk(req, res64, {{32{y[31]}}, y});
      chk(req, {32'd0, res32}, {32'd0, y});
      chk(req, {59'd0, rd64}, {59'd0, i[11:7]});
      chk(req, {59'd0, rd32}, {59'd0, i[11:7]});
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] last_res;
    #20;
    // R11
    chk("R11", {res64[31:0], 27'd0, rd64, 30'd0, v64, ill64}, 64'd0);
    chk("R11", {res32, 27'd0, rd32}, 64'd0);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      string tag;
      logic [4:0] sel;
      tag = (s == 0) ? "R5" : (s == 1) ? "R6" : (s == 2) ? "R3" : "R4";
      sel = 5'(s);
      // zero, all-ones, single bits, random
      run(tag, mk(7'b0001000, sel, 5'd3, 3'b001, 7'b0010011), 64'd0, 1'b1, 1, s);
      run(tag, mk(7'b0001000, sel, 5'd4, 3'b001, 7'b0010011), '1, 1'b1, 1, s);
      for (int b = 0; b < 32; b++)
        run(tag, mk(7'b0001000, sel, 5'(b), 3'b001, 7'b0010011), 64'd1 << b, 1'b1, 1, s);
      for (int k = 0; k < 40; k++) begin
        logic [63:0] op;
        op = {nxt(), nxt()};
        // R7 upper rs1 bits are random and must not matter
        run("R7", mk(7'b0001000, sel, 5'(k), 3'b001, 7'b0010011), op, 1'b1, 1, s);
      end
    end

    // R10 every destination including register 0
    for (int r = 0; r < 32; r++)
      run("R10", mk(7'b0001000, 5'd2, 5'(r), 3'b001, 7'b0010011), {nxt(), nxt()}, 1'b1, 1, 2);

    // R2 unused selectors
    for (int s = 4; s < 32; s++)
      run("R2", mk(7'b0001000, 5'(s), 5'd1, 3'b001, 7'b0010011), 64'h5, 1'b1, 0, 0);

    // R1 field mismatches
    for (int b = 0; b < 7; b++)
      run("R1", mk(7'b0001000 ^ 7'(1 << b), 5'd0, 5'd1, 3'b001, 7'b0010011), 64'h5, 1'b1, 0, 0);
    for (int b = 0; b < 3; b++)
      run("R1", mk(7'b0001000, 5'd1, 5'd1, 3'b001 ^ 3'(1 << b), 7'b0010011), 64'h5, 1'b1, 0, 0);
    for (int b = 0; b < 7; b++)
      run("R1", mk(7'b0001000, 5'd3, 5'd1, 3'b001, 7'b0010011 ^ 7'(1 << b)), 64'h5, 1'b1, 0, 0);

    // R8 extension disabled
    for (int s = 0; s < 4; s++)
      run("R8", mk(7'b0001000, 5'(s), 5'd9, 3'b001, 7'b0010011), 64'h1234, 1'b0, 0, 0);

    // R12 idle: flags clear, result and rd hold
    run("R12", mk(7'b0001000, 5'd1, 5'd17, 3'b001, 7'b0010011), 64'hdead_beef_8000_0001, 1'b1, 1, 1);
    last_res = res64;
    @(negedge clk);
    valid = 1'b0; insn = mk(7'b0001000, 5'd0, 5'd2, 3'b001, 7'b0010011); rs1 = '1; en = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #1;
      chk("R12", {62'd0, v64, ill64}, 64'd0);
      chk("R12", res64, last_res);
      chk("R12", {59'd0, rd64}, 64'd17);
    end

    // R9 illegal flag lasts one cycle
    run("R9", mk(7'b0000000, 5'd0, 5'd2, 3'b001, 7'b0010011), 64'd1, 1'b1, 0, 0);
    @(negedge clk);
    valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R9", {62'd0, v64, ill64}, 64'd0);
    chk("R12", res64, last_res);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule